// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Unit

This block produces a coarse reciprocal estimate of a floating-point operand by keeping only its exponent information. For an ordinary operand the fraction is cleared, the sign is carried through and every bit of the exponent field is inverted. This gives a power-of-two scale factor that iterative reciprocal or division routines use to pre-scale their inputs. The unit handles half, single and double precision, chosen per operation by a format select. Narrower operands sit in the low bits of a 64-bit bus.

NaN operands bypass the exponent path. A quiet NaN passes through unchanged. A signaling NaN is quieted and raises the invalid-operation flag. When the default-NaN control is set, every NaN result is replaced by the format's canonical NaN. A flush control replaces subnormal operands with a zero of the same sign before processing. The unit is one registered stage: a request marked by `in_valid` yields its result with `out_valid` on the following clock edge.

Top module: `recip_exp_unit`

## Requirements
- R1: After reset `out_valid` is low and `out_result` is zero. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high.
- R2: `in_fmt` 2'b00 selects half (operand in bits [15:0], exponent [14:10]); 2'b01 selects single (bits [31:0], exponent [30:23]); 2'b10 and 2'b11 select double (bits [63:0], exponent [62:52]). Operand bits above the selected width are ignored, and result bits above it are zero.
- R3: For a non-NaN operand with a nonzero exponent field, the result has the operand's sign bit, an all-zero fraction and an exponent field that is the bitwise inverse of the operand's. The invalid flag is low.
- R4: An operand whose exponent field is zero yields exponent 0x1E (half), 0xFE (single) or 0x7FE (double), with the operand's sign and a zero fraction.
- R5: An infinity (exponent all ones, fraction zero) yields a zero of the same sign.
- R6: A signaling NaN (exponent all ones, fraction MSB at bit 9/22/51 clear, fraction nonzero) sets `out_invalid` and returns the operand with that fraction MSB set.
- R7: A quiet NaN (fraction MSB set) is returned unchanged, with `out_invalid` low.
- R8: With `dnan_en` high, any NaN operand returns 0x7E00, 0x7FC00000 or 0x7FF8000000000000 for half, single and double. A signaling NaN still sets `out_invalid`.
- R9: A subnormal operand gives the same result as a zero of its sign, whether `flush_en` is high or low.
- R10: In a cycle after `in_valid` was low, `out_valid` and `out_invalid` are low and `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Precision select (00 half, 01 single, 1x double) |
| in_opnd | input | 64 | Operand, right-aligned |
| flush_en | input | 1 | Flush subnormal operands to zero |
| dnan_en | input | 1 | Replace NaN results with the default NaN |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Result, right-aligned, upper bits zero |
| out_invalid | output | 1 | Invalid-operation flag for this result |

## Verification
The assertions assume that `in_valid`, `in_fmt`, `in_opnd`, `flush_en` and `dnan_en` always hold known values while reset is released. They sample the operand fields in the request cycle and compare them with the output one cycle later. The stimulus sets every input at the falling edge and holds it through the next rising edge. It keeps the controls driven even while idle, so no request or idle cycle ever sees an undefined format or operand.

// File: rtl/frx_pkg.sv
package frx_pkg;

    localparam int unsigned FRX_DATA_W = 64;
    localparam int unsigned FRX_LANES  = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_DOUBLE_ALT = 2'b11
    } frx_fmt_e;

    typedef struct packed {
        logic                  valid;
        logic                  invalid;
        logic [FRX_DATA_W-1:0] result;
    } frx_stage_t;

    function automatic int unsigned lane_exp_w(input int unsigned idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int unsigned lane_frac_w(input int unsigned idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/frx_classify.sv
module frx_classify #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]      opnd,
    input  logic              flush_en,
    output logic              sign,
    output logic [EXP_W-1:0]  expo,
    output logic [FRAC_W-1:0] frac,
    output logic              is_nan,
    output logic              is_snan,
    output logic              is_zero,
    output logic              is_sub
);

    logic exp_ones;
    logic exp_none;
    logic frac_any;

    always_comb begin
        sign     = opnd[W-1];
        expo     = opnd[W-2 -: EXP_W];
        frac     = opnd[FRAC_W-1:0];
        exp_ones = &expo;
        exp_none = ~|expo;
        frac_any = |frac;
        is_nan   = exp_ones && frac_any;
        is_snan  = is_nan && !frac[FRAC_W-1];
        // a flushed subnormal counts as a signed zero
        is_zero  = exp_none && (!frac_any || flush_en);
        is_sub   = exp_none && frac_any && !flush_en;
    end

endmodule

// File: rtl/frx_lane.sv
module frx_lane #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] opnd,
    input  logic         flush_en,
    input  logic         dnan_en,
    output logic [W-1:0] res,
    output logic         invalid
);

    localparam logic [EXP_W-1:0]  EXP_MAX_FIN = {{(EXP_W-1){1'b1}}, 1'b0};
    localparam logic [EXP_W-1:0]  EXP_ONES    = '1;
    localparam logic [FRAC_W-1:0] FRAC_QBIT   = FRAC_W'(1) << (FRAC_W - 1);

    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              is_nan;
    logic              is_snan;
    logic              is_zero;
    logic              is_sub;

    frx_classify #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_classify (
        .opnd     (opnd),
        .flush_en (flush_en),
        .sign     (sign),
        .expo     (expo),
        .frac     (frac),
        .is_nan   (is_nan),
        .is_snan  (is_snan),
        .is_zero  (is_zero),
        .is_sub   (is_sub)
    );

    logic [EXP_W-1:0] exp_new;

    always_comb begin
        if (is_zero || is_sub) begin
            exp_new = EXP_MAX_FIN;
        end else begin
            exp_new = ~expo;
        end

        invalid = is_snan;
        if (is_nan) begin
            if (dnan_en) begin
                res = {1'b0, EXP_ONES, FRAC_QBIT};
            end else begin
                res = {sign, expo, frac | FRAC_QBIT};
            end
        end else begin
            res = {sign, exp_new, {FRAC_W{1'b0}}};
        end
    end

endmodule

// File: rtl/recip_exp_unit.sv
module recip_exp_unit
    import frx_pkg::*;
#(
    parameter int unsigned DATA_W = FRX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_fmt,
    input  logic [DATA_W-1:0] in_opnd,
    input  logic              flush_en,
    input  logic              dnan_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_invalid
);

    logic [DATA_W-1:0] lane_res [FRX_LANES];
    logic              lane_inv [FRX_LANES];

    for (genvar g = 0; g < FRX_LANES; g++) begin : g_lane
        localparam int unsigned EW = lane_exp_w(g);
        localparam int unsigned FW = lane_frac_w(g);
        localparam int unsigned LW = 1 + EW + FW;

        logic [LW-1:0] res_w;
        logic          inv_w;

        frx_lane #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_lane (
            .opnd     (in_opnd[LW-1:0]),
            .flush_en (flush_en),
            .dnan_en  (dnan_en),
            .res      (res_w),
            .invalid  (inv_w)
        );

        assign lane_res[g] = DATA_W'(res_w);
        assign lane_inv[g] = inv_w;
    end

    frx_stage_t st_d;
    frx_stage_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.invalid = 1'b0;
        if (in_valid) begin
            unique case (frx_fmt_e'(in_fmt))
                FMT_HALF: begin
                    st_d.result  = lane_res[0];
                    st_d.invalid = lane_inv[0];
                end
                FMT_SINGLE: begin
                    st_d.result  = lane_res[1];
                    st_d.invalid = lane_inv[1];
                end
                FMT_DOUBLE, FMT_DOUBLE_ALT: begin
                    st_d.result  = lane_res[2];
                    st_d.invalid = lane_inv[2];
                end
                default: begin
                    st_d.result  = lane_res[2];
                    st_d.invalid = lane_inv[2];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_invalid = st_q.invalid;

endmodule

// File: rtl/frx_checker.sv
module frx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  in_fmt,
    input logic [63:0] in_opnd,
    input logic        dnan_en,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_invalid
);

    assert_valid_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_invalid && $stable(out_result)));

    assert_half_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'b00) |=> (out_result[63:16] == 48'h0));

    assert_single_finite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'b01 && in_opnd[30:23] != 8'hFF)
        |=> (out_result[22:0] == 23'h0 && !out_invalid
             && out_result[31] == $past(in_opnd[31])));

    assert_double_snan_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'b10 && in_opnd[62:52] == 11'h7FF
         && !in_opnd[51] && |in_opnd[50:0]) |=> out_invalid);

    assert_half_qnan_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'b00 && !dnan_en && in_opnd[14:10] == 5'h1F
         && in_opnd[9]) |=> (out_result[15:0] == $past(in_opnd[15:0]) && !out_invalid));

    assert_invalid_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_valid);

endmodule

bind recip_exp_unit frx_checker u_frx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_fmt      (in_fmt),
    .in_opnd     (in_opnd),
    .dnan_en     (dnan_en),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid)
);

// File: tb/recip_exp_unit_bench.sv
`timescale 1ns/1ps
module recip_exp_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = 2'b00;
    logic [63:0] in_opnd = 64'h0;
    logic        flush_en = 1'b0;
    logic        dnan_en = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    recip_exp_unit u_recip_exp_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_fmt      (in_fmt),
        .in_opnd     (in_opnd),
        .flush_en    (flush_en),
        .dnan_en     (dnan_en),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one request, result sampled on the falling edge after the capturing rising edge
    task automatic run_op(input string req, input logic [1:0] fmt, input logic [63:0] opnd,
                          input logic ftz, input logic dn,
                          input logic [63:0] exp_res, input logic exp_inv);
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = fmt;
        in_opnd  = opnd;
        flush_en = ftz;
        dnan_en  = dn;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 64'(out_valid), 64'h1);
        check({req, " result"}, out_result, exp_res);
        check({req, " invalid"}, 64'(out_invalid), 64'(exp_inv));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset valid", 64'(out_valid), 64'h0);
        check("R1 reset result", out_result, 64'h0);
        check("R1 reset invalid", 64'(out_invalid), 64'h0);
    endtask

    task automatic t_normal;
        run_op("R3 half 1.0", 2'b00, 64'h3C00, 1'b0, 1'b0, 64'h4000, 1'b0);
        run_op("R3 half -1.0", 2'b00, 64'hBC00, 1'b0, 1'b0, 64'hC000, 1'b0);
        run_op("R3 half 3.14", 2'b00, 64'h4248, 1'b0, 1'b0, 64'h3C00, 1'b0);
        run_op("R3 single 1.0", 2'b01, 64'h3F80_0000, 1'b0, 1'b0, 64'h4000_0000, 1'b0);
        run_op("R3 single -pi", 2'b01, 64'hC049_0FDB, 1'b0, 1'b0, 64'hBF80_0000, 1'b0);
        run_op("R3 double 1.0", 2'b10, 64'h3FF0_0000_0000_0000, 1'b0, 1'b0,
               64'h4000_0000_0000_0000, 1'b0);
    endtask

    task automatic t_format;
        run_op("R2 half upper ignored", 2'b00, 64'hFFFF_FFFF_FFFF_3C00, 1'b0, 1'b0, 64'h4000, 1'b0);
        run_op("R2 single upper ignored", 2'b01, 64'hABCD_1234_3F80_0000, 1'b0, 1'b0,
               64'h4000_0000, 1'b0);
        run_op("R2 fmt 11 as double", 2'b11, 64'h3FF0_0000_0000_0000, 1'b0, 1'b0,
               64'h4000_0000_0000_0000, 1'b0);
    endtask

    task automatic t_zero_exp;
        run_op("R4 half +0", 2'b00, 64'h0000, 1'b0, 1'b0, 64'h7800, 1'b0);
        run_op("R4 half -0", 2'b00, 64'h8000, 1'b0, 1'b0, 64'hF800, 1'b0);
        run_op("R4 single +0", 2'b01, 64'h0, 1'b0, 1'b0, 64'h7F00_0000, 1'b0);
        run_op("R4 double -0", 2'b10, 64'h8000_0000_0000_0000, 1'b0, 1'b0,
               64'hFFE0_0000_0000_0000, 1'b0);
    endtask

    task automatic t_infinity;
        run_op("R5 half +inf", 2'b00, 64'h7C00, 1'b0, 1'b0, 64'h0000, 1'b0);
        run_op("R5 half -inf", 2'b00, 64'hFC00, 1'b0, 1'b0, 64'h8000, 1'b0);
        run_op("R5 double -inf", 2'b10, 64'hFFF0_0000_0000_0000, 1'b0, 1'b0,
               64'h8000_0000_0000_0000, 1'b0);
    endtask

    task automatic t_nan;
        run_op("R6 half snan", 2'b00, 64'h7C01, 1'b0, 1'b0, 64'h7E01, 1'b1);
        run_op("R6 single snan", 2'b01, 64'h7F80_0001, 1'b0, 1'b0, 64'h7FC0_0001, 1'b1);
        run_op("R6 double snan", 2'b10, 64'hFFF0_0000_0000_0001, 1'b0, 1'b0,
               64'hFFF8_0000_0000_0001, 1'b1);
        run_op("R7 half qnan", 2'b00, 64'hFE05, 1'b0, 1'b0, 64'hFE05, 1'b0);
        run_op("R7 single qnan", 2'b01, 64'h7FC1_2345, 1'b0, 1'b0, 64'h7FC1_2345, 1'b0);
    endtask

    task automatic t_default_nan;
        run_op("R8 half snan dn", 2'b00, 64'hFC01, 1'b0, 1'b1, 64'h7E00, 1'b1);
        run_op("R8 single qnan dn", 2'b01, 64'hFFC0_0000, 1'b0, 1'b1, 64'h7FC0_0000, 1'b0);
        run_op("R8 double snan dn", 2'b10, 64'h7FF0_0000_0000_0001, 1'b0, 1'b1,
               64'h7FF8_0000_0000_0000, 1'b1);
        run_op("R8 dn normal unaffected", 2'b00, 64'h3C00, 1'b0, 1'b1, 64'h4000, 1'b0);
    endtask

    task automatic t_subnormal;
        run_op("R9 half sub no flush", 2'b00, 64'h0001, 1'b0, 1'b0, 64'h7800, 1'b0);
        run_op("R9 half sub flush", 2'b00, 64'h0001, 1'b1, 1'b0, 64'h7800, 1'b0);
        run_op("R9 single -sub flush", 2'b01, 64'h8000_0001, 1'b1, 1'b0, 64'hFF00_0000, 1'b0);
        run_op("R9 double sub no flush", 2'b10, 64'h000F_FFFF_FFFF_FFFF, 1'b0, 1'b0,
               64'h7FE0_0000_0000_0000, 1'b0);
    endtask

    task automatic t_idle;
        run_op("R10 setup snan", 2'b00, 64'h7C01, 1'b0, 1'b0, 64'h7E01, 1'b1);
        @(negedge clk);
        in_opnd = 64'h3C00;
        @(negedge clk);
        check("R10 idle valid", 64'(out_valid), 64'h0);
        check("R10 idle invalid", 64'(out_invalid), 64'h0);
        check("R10 idle result held", out_result, 64'h7E01);
        check("R1 back to valid after idle", 64'(out_valid), 64'h0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = 2'b01;
        in_opnd  = 64'h3F80_0000;
        flush_en = 1'b0;
        dnan_en  = 1'b0;
        @(negedge clk);
        check("R1 b2b first", out_result, 64'h4000_0000);
        in_fmt  = 2'b00;
        in_opnd = 64'h7C01;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 b2b second valid", 64'(out_valid), 64'h1);
        check("R6 b2b second result", out_result, 64'h7E01);
        check("R6 b2b second invalid", 64'(out_invalid), 64'h1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_normal();
        t_format();
        t_zero_exp();
        t_infinity();
        t_nan();
        t_default_nan();
        t_subnormal();
        t_idle();
        t_back_to_back();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule